// File: doc/BRIEF.md
# Cluster Interrupt Controller with Index-Addressed Enables

This block gathers a set of level-sensitive interrupt sources and delivers them to a small group of processors, by default 64 sources and 4 CPUs. A source reaches a CPU only when it is globally switched on, steered to that CPU and not blocked by that CPU's own mask. Each CPU has one interrupt output. A CPU finds out which source to service by reading an identification register that names the lowest-numbered source pending for it, or returns a fixed idle code.

Software reaches the block through one read/write port. A window-select input picks either the shared register window or the private window of the CPU named on the CPU-number input. Global enables and per-CPU masks are not written as bitmaps. Software writes a source number to a "switch on" or "switch off" register. Each source has its own steering word. Sources 0 and 1 are ordinary inputs that a neighbouring block drives with its doorbell summaries.

Top module: `cluster_intc`

## Requirements
- R1: After reset every source is globally off, masked on every CPU and steered to no CPU. All `irq_o` bits are low, the identification register reads 1023 and every steering word reads 0, even with all source levels high.
- R2: Writing a source number to shared offset 0x030 switches that source on globally. Writing it to shared offset 0x034 switches it off.
- R3: In the private window, writing a source number to offset 0x048 masks that source for the CPU on `bus_cpu` only. Writing it to offset 0x04C unmasks it for that CPU only.
- R4: The steering word of source n is at shared offset 0x100 + 4·n. Bit c sends the source to CPU c. Bits at and above NUM_CPU are discarded on write and read as 0.
- R5: A source is pending for CPU c when its level is high, it is switched on, it is steered to c and it is unmasked on c. `irq_o[c]` is the OR of those pending sources and follows them one clock later.
- R6: A read of private offset 0x044 returns the number of the lowest-numbered source pending for that CPU in bits [9:0], with all upper bits zero.
- R7: The identification read returns 1023 when no source is pending for that CPU.
- R8: Shared offset 0x000 reads the number of sources in bits [11:2], with every other bit zero.
- R9: Private offset 0x010 + 4·k reads a bitmap of the sources pending for that CPU. Bit i of word k stands for source 32·k + i.
- R10: A switch-on, switch-off, mask or unmask write whose data is NUM_SRC or larger changes nothing. A steering write to an offset beyond the last source changes nothing. In particular none of these wraps onto a low source.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled. Levels are never latched, so when a source falls it stops being pending and the next lower-priority source is named.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_SRC | Source levels, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_cpu_win | input | 1 | 1 selects the private window of `bus_cpu`, 0 the shared window |
| bus_cpu | input | CPU_W | Number of the CPU making the access |
| bus_addr | input | 12 | Byte offset inside the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CPU | Interrupt request per CPU |

## Verification
Stimulus first holds every source high while the enables, masks and steering are still at reset, so that any leak through a default is exposed. It then raises a few sources one gate at a time. Each step toggles a single gate: global switch, steering bit or per-CPU mask. This shows that each gate is needed and that a mask touches only the writing CPU. Overlapping sources at 0, 5 and 40 are then withdrawn one by one, which separates lowest-first selection from any other order and shows that nothing is latched. Writes of index 64 and a steering write one word past the last source prove that out-of-range indices do not wrap onto source 0. Source 63 checks the top bit of the second bitmap word.

// File: rtl/cluster_intc_pkg.sv
package cluster_intc_pkg;
    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int ID_W    = 10;
    localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;

    // shared window
    localparam logic [AW-1:0] G_INFO      = 12'h000;
    localparam logic [AW-1:0] G_ON        = 12'h030;
    localparam logic [AW-1:0] G_OFF       = 12'h034;
    localparam logic [AW-1:0] G_STEER     = 12'h100;
    // private window
    localparam logic [AW-1:0] P_BITMAP    = 12'h010;
    localparam logic [AW-1:0] P_IDENT     = 12'h044;
    localparam logic [AW-1:0] P_BLOCK     = 12'h048;
    localparam logic [AW-1:0] P_UNBLOCK   = 12'h04C;
endpackage

// File: rtl/cluster_intc_pend.sv
module cluster_intc_pend #(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]              lvl,
    input  logic [NUM_SRC-1:0]              on,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0] blk,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0] steer,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0] pend
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign pend[c][s] = lvl[s] & on[s] & steer[s][c] & ~blk[c][s];
        end
    end
endmodule

// File: rtl/cluster_intc_pick.sv
module cluster_intc_pick #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx
);
    // lowest set bit wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/cluster_intc.sv
module cluster_intc
    import cluster_intc_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_cpu_win,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [NUM_CPU-1:0] irq_o
);
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int WORDS   = (NUM_SRC + DW - 1) / DW;
    localparam int PAD_W   = WORDS * DW;

    typedef struct packed {
        logic [NUM_SRC-1:0]              on;
        logic [NUM_CPU-1:0][NUM_SRC-1:0] blk;
        logic [NUM_SRC-1:0][NUM_CPU-1:0] steer;
        logic [DW-1:0]                   rdata;
        logic [NUM_CPU-1:0]              irq;
    } state_t;

    state_t s_q, s_d;

    logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;
    logic [NUM_CPU-1:0]              hit;
    logic [NUM_CPU-1:0][SRC_W-1:0]   pick_idx;
    logic [NUM_CPU-1:0][ID_W-1:0]    ident;

    cluster_intc_pend #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_pend (
        .lvl   (src_lvl),
        .on    (s_q.on),
        .blk   (s_q.blk),
        .steer (s_q.steer),
        .pend  (pend)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_pick
        cluster_intc_pick #(.N(NUM_SRC), .W(SRC_W)) u_pick (
            .vec (pend[c]),
            .hit (hit[c]),
            .idx (pick_idx[c])
        );
        assign ident[c] = hit[c] ? ID_W'(pick_idx[c]) : IDLE_ID;
    end

    // address and data decode
    logic              cpu_ok;
    logic              idx_ok;
    logic [SRC_W-1:0]  widx;
    logic [AW-1:0]     steer_off;
    logic [AW-1:0]     steer_sel;
    logic              steer_hit;
    logic [AW-1:0]     map_off;
    logic [AW-1:0]     map_sel;
    logic              map_hit;
    logic [PAD_W-1:0]  map_pad;
    logic [DW-1:0]     map_word;
    logic [DW-1:0]     rd_val;

    always_comb begin
        cpu_ok    = int'(bus_cpu) < NUM_CPU;
        idx_ok    = bus_wdata < DW'(NUM_SRC);
        widx      = bus_wdata[SRC_W-1:0];

        steer_off = bus_addr - G_STEER;
        steer_sel = steer_off >> 2;
        steer_hit = !bus_cpu_win && (bus_addr >= G_STEER) &&
                    (bus_addr[1:0] == 2'b00) && (int'(steer_sel) < NUM_SRC);

        map_off   = bus_addr - P_BITMAP;
        map_sel   = map_off >> 2;
        map_hit   = bus_cpu_win && (bus_addr >= P_BITMAP) &&
                    (bus_addr[1:0] == 2'b00) && (int'(map_sel) < WORDS);
        map_pad   = PAD_W'(pend[bus_cpu]);
        map_word  = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (int'(map_sel) == k) map_word = map_pad[k*DW +: DW];
        end
    end

    // read selection
    always_comb begin
        rd_val = '0;
        if (bus_cpu_win) begin
            if (cpu_ok) begin
                if (bus_addr == P_IDENT) rd_val = DW'(ident[bus_cpu]);
                else if (map_hit)        rd_val = map_word;
            end
        end else begin
            if (bus_addr == G_INFO)  rd_val = DW'(NUM_SRC) << 2;
            else if (steer_hit)      rd_val = DW'(s_q.steer[steer_sel[SRC_W-1:0]]);
        end
    end

    // next state
    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NUM_CPU; c++) s_d.irq[c] = |pend[c];
        if (bus_rd) s_d.rdata = rd_val;
        if (bus_wr) begin
            if (!bus_cpu_win) begin
                if (bus_addr == G_ON && idx_ok)       s_d.on[widx] = 1'b1;
                else if (bus_addr == G_OFF && idx_ok) s_d.on[widx] = 1'b0;
                else if (steer_hit)
                    s_d.steer[steer_sel[SRC_W-1:0]] = bus_wdata[NUM_CPU-1:0];
            end else if (cpu_ok && idx_ok) begin
                if (bus_addr == P_BLOCK)        s_d.blk[bus_cpu][widx] = 1'b1;
                else if (bus_addr == P_UNBLOCK) s_d.blk[bus_cpu][widx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.on    <= '0;
            s_q.blk   <= '1;
            s_q.steer <= '0;
            s_q.rdata <= '0;
            s_q.irq   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign irq_o     = s_q.irq;
endmodule

// File: rtl/cluster_intc_chk.sv
module cluster_intc_chk
    import cluster_intc_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic               bus_rd,
    input logic               bus_cpu_win,
    input logic [CPU_W-1:0]   bus_cpu,
    input logic [AW-1:0]      bus_addr,
    input logic [DW-1:0]      bus_rdata,
    input logic [NUM_CPU-1:0] irq_o
);
    logic ident_rd;
    assign ident_rd = bus_rd && bus_cpu_win && (bus_addr == P_IDENT) &&
                      (int'(bus_cpu) < NUM_CPU);

    assert_ident_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ident_rd |=> (bus_rdata < DW'(NUM_SRC)) || (bus_rdata == DW'(IDLE_ID)));

    assert_ident_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_rd && (src_lvl == '0)) |=> (bus_rdata == DW'(IDLE_ID)));

    assert_info_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_cpu_win && (bus_addr == G_INFO)) |=>
            (bus_rdata == (DW'(NUM_SRC) << 2)));

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvl == '0) |=> (irq_o == '0));

    assert_steer_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_cpu_win && (bus_addr == G_STEER)) |=>
            ((bus_rdata >> NUM_CPU) == '0));
endmodule

bind cluster_intc cluster_intc_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_lvl     (src_lvl),
    .bus_rd      (bus_rd),
    .bus_cpu_win (bus_cpu_win),
    .bus_cpu     (bus_cpu),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o)
);

// File: tb/cluster_intc_tb.sv
module cluster_intc_tb;
    localparam int NC = 4;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_lvl = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_cpu_win = 1'b0;
    logic [1:0]    bus_cpu = '0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_flag = 1'b0;

    always #2.5 clk = ~clk;

    cluster_intc #(.NUM_CPU(NC), .NUM_SRC(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu_win(bus_cpu_win),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_flag <= bus_rd;
    always @(negedge clk) begin
        if (rd_flag) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: read got 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic win, input int cpu, input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu_win = win; bus_cpu = 2'(cpu);
        bus_addr = 12'(addr); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic win, input int cpu, input int addr,
                      input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_cpu_win = win; bus_cpu = 2'(cpu); bus_addr = 12'(addr);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_src(input logic [NS-1:0] v);
        @(negedge clk);
        src_lvl = v;
    endtask

    task automatic chk_irq(input logic [NC-1:0] e, input string t);
        @(negedge clk);
        n_cmp++;
        if (irq_o !== e) begin
            n_bad++;
            $display("FAIL %s: irq_o got %b expected %b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected end");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8 / R1 reset state
        rd(0, 0, 12'h000, 32'd256, "R8 info count");
        rd(1, 0, 12'h044, 32'd1023, "R1 ident idle after reset");
        chk_irq(4'b0000, "R1 irq low after reset");
        rd(0, 0, 12'h114, 32'd0, "R1 steering cleared");
        set_src('1);
        chk_irq(4'b0000, "R1 all levels high but everything off");
        rd(1, 3, 12'h010, 32'd0, "R1 bitmap empty");

        // build up sources 5 and 40
        set_src((64'd1 << 5) | (64'd1 << 40));
        wr(0, 0, 12'h114, 32'hFFFF_FFF1);
        rd(0, 0, 12'h114, 32'd1, "R4 steering upper bits dropped");
        wr(0, 0, 12'h1A0, 32'd3);
        wr(0, 0, 12'h030, 32'd5);
        wr(0, 0, 12'h030, 32'd40);
        chk_irq(4'b0000, "R3 still masked from reset");
        wr(1, 0, 12'h04C, 32'd5);
        wr(1, 0, 12'h04C, 32'd40);
        chk_irq(4'b0001, "R5 cpu0 sees pending");
        rd(1, 0, 12'h044, 32'd5, "R6 lowest pending on cpu0");
        rd(1, 0, 12'h010, 32'h0000_0020, "R9 bitmap word0");
        rd(1, 0, 12'h014, 32'h0000_0100, "R9 bitmap word1");
        rd(1, 1, 12'h044, 32'd1023, "R3 cpu0 unmask leaves cpu1 masked");
        wr(1, 1, 12'h04C, 32'd40);
        wr(1, 1, 12'h04C, 32'd5);
        chk_irq(4'b0011, "R5 cpu1 joins");
        rd(1, 1, 12'h044, 32'd40, "R4 source 5 not steered to cpu1");
        wr(1, 0, 12'h048, 32'd5);
        rd(1, 0, 12'h044, 32'd40, "R3 mask hides 5 on cpu0");
        wr(0, 0, 12'h034, 32'd40);
        chk_irq(4'b0000, "R2 switch-off removes 40");
        rd(1, 0, 12'h044, 32'd1023, "R7 idle code");

        // out-of-range indices on source 0
        set_src((64'd1 << 5) | (64'd1 << 40) | 64'd1);
        wr(0, 0, 12'h100, 32'd4);
        wr(1, 2, 12'h04C, 32'd0);
        wr(0, 0, 12'h030, 32'd64);
        chk_irq(4'b0000, "R10 switch-on 64 ignored");
        wr(0, 0, 12'h030, 32'd0);
        chk_irq(4'b0100, "R2 switch-on source 0");
        rd(1, 2, 12'h044, 32'd0, "R6 cpu2 names source 0");
        wr(0, 0, 12'h034, 32'd64);
        wr(1, 2, 12'h048, 32'd64);
        chk_irq(4'b0100, "R10 switch-off and mask of 64 ignored");
        wr(0, 0, 12'h200, 32'hF);
        rd(0, 0, 12'h100, 32'd4, "R10 steering past last source ignored");

        // lowest first, level behaviour
        wr(0, 0, 12'h100, 32'd5);
        wr(1, 0, 12'h04C, 32'd0);
        wr(1, 0, 12'h04C, 32'd5);
        wr(0, 0, 12'h030, 32'd5);
        wr(0, 0, 12'h030, 32'd40);
        rd(1, 0, 12'h044, 32'd0, "R6 lowest of 0,5,40");
        chk_irq(4'b0111, "R5 three cpus active");
        set_src((64'd1 << 5) | (64'd1 << 40));
        rd(1, 0, 12'h044, 32'd5, "R11 source 0 dropped");
        set_src(64'd1 << 40);
        rd(1, 0, 12'h044, 32'd40, "R11 source 5 dropped");
        set_src('0);
        chk_irq(4'b0000, "R11 all levels low");
        rd(1, 0, 12'h044, 32'd1023, "R7 idle after drop");

        // top source
        wr(0, 0, 12'h1FC, 32'd8);
        wr(0, 0, 12'h030, 32'd63);
        wr(1, 3, 12'h04C, 32'd63);
        set_src(64'd1 << 63);
        chk_irq(4'b1000, "R5 source 63 to cpu3");
        rd(1, 3, 12'h044, 32'd63, "R6 top source");
        rd(1, 3, 12'h014, 32'h8000_0000, "R9 top bitmap bit");
        rd(1, 3, 12'h010, 32'd0, "R9 low word empty");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule